// File: doc/BRIEF.md
# Key-Sequence Hardware Watchdog

This block is a watchdog for a small 8-bit microcontroller. It listens to a plain register write bus (address, data byte, write strobe) and is started only by writing a fixed two-byte key to one write-only key register. The same key also services it. Once it has started, it counts machine cycles. Software cannot stop it. Only an external reset, or the end of its own reset pulse, brings it back to the idle state.

If the main counter reaches its all-ones value before the next service, the block drives a reset output high for a fixed number of oscillator clocks. A neighbouring configuration register holds a power-of-two prescale select that stretches the timeout. The counter and the prescaler cannot be read or written over the bus.

Top module: `seq_wdt`

## Requirements
- R1: After an external reset `wdt_rst_o` is low and the watchdog is idle. Without a key sequence it never raises `wdt_rst_o`.
- R2: The watchdog starts when the key register (address 0xA6) receives 0x1E and then 0xE1. Writes to other addresses do not disturb the tracker. Any other value written to 0xA6 clears it, so a following 0xE1 does nothing. 0xE1 alone, the reverse order, or 0xE1 to another address does not start it.
- R3: Once running, no bus write stops it, whatever the value or address. Only an external `rst` or the end of its own pulse returns it to idle.
- R4: A completed key sequence while running clears the main counter, the prescaler and the machine-cycle divider. The timeout is then measured again from that write.
- R5: One machine cycle is 12 clocks. The main counter (CNT_W bits, 14 by default) advances once every machine cycle times the prescale ratio, and expires at its all-ones value (16383 by default).
- R6: With prescale ratio D, `wdt_rst_o` goes high exactly 2 + 12·D·(2^CNT_W − 1) rising edges after the edge that accepted the completing 0xE1 write.
- R7: Each expiry raises `wdt_rst_o` for exactly 96 consecutive clocks.
- R8: When the pulse ends, all watchdog state returns to idle. This includes the prescale select, which reads 0 (ratio 1).
- R9: A write to address 0xA7 sets the prescale select from data bits [2:0] (value s, ratio 2^s, 1 to 128). Higher data bits are ignored. External reset clears the select to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high external reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| wdt_rst_o | output | 1 | Registered watchdog reset pulse |

## Verification
The key tracker registers a kick one edge after the 0xE1 write. The counter stage restarts on the next edge. The first machine-cycle tick then takes 12 clocks, and the pulse register adds one more edge. This gives rise times of 374 edges at ratio 1, 1490 at ratio 4 and 47618 at ratio 128 with the bench's 5-bit counter. The bench counts falling edges from the write that completed the key. It checks that the output is still low one edge before the computed rise and high exactly at it. It then counts high samples to check the 96-clock width. Sequences that must not start the watchdog get a quiet window more than twice as long as the shortest timeout.

// File: rtl/seq_wdt_pkg.sv
package seq_wdt_pkg;
  typedef enum logic {
    TRK_IDLE = 1'b0,
    TRK_HALF = 1'b1
  } trk_state_t;
endpackage

// File: rtl/seq_wdt_mcgen.sv
module seq_wdt_mcgen #(
  parameter int OSC_PER_MC = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic restart,
  output logic tick
);
  localparam int MC_W = (OSC_PER_MC > 1) ? $clog2(OSC_PER_MC) : 1;
  localparam logic [MC_W-1:0] LAST = MC_W'(OSC_PER_MC - 1);

  logic [MC_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (clr || restart || phase == LAST) phase <= '0;
    else                                 phase <= phase + 1'b1;
  end

  assign tick = (phase == LAST);

  generate
    if (OSC_PER_MC > 1) begin : g_gap
      // R5
      tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/seq_wdt_unlock.sv
module seq_wdt_unlock
  import seq_wdt_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 8,
  parameter logic [7:0]  KEY_ADDR   = 8'hA6,
  parameter logic [7:0]  KEY_FIRST  = 8'h1E,
  parameter logic [7:0]  KEY_SECOND = 8'hE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              kick
);
  trk_state_t trk;
  logic       key_hit;

  assign key_hit = wr_en && (wr_addr == ADDR_W'(KEY_ADDR));

  always_ff @(posedge clk) begin
    if (clr) begin
      trk  <= TRK_IDLE;
      kick <= 1'b0;
    end else begin
      kick <= 1'b0;
      if (key_hit) begin
        if (wr_data == DATA_W'(KEY_FIRST)) begin
          trk <= TRK_HALF;
        end else begin
          trk <= TRK_IDLE;
          if (trk == TRK_HALF && wr_data == DATA_W'(KEY_SECOND)) kick <= 1'b1;
        end
      end
    end
  end

  // R2
  kick_src_chk: assert property (@(posedge clk) disable iff (rst)
    kick |-> $past(wr_en && wr_addr == ADDR_W'(KEY_ADDR) && wr_data == DATA_W'(KEY_SECOND)));
endmodule

// File: rtl/seq_wdt_timer.sv
module seq_wdt_timer #(
  parameter int CNT_W  = 14,
  parameter int PSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              kick,
  input  logic              tick,
  input  logic [PSEL_W-1:0] sel,
  output logic              expire
);
  localparam int PRE_W = (1 << PSEL_W) - 1;

  logic             running;
  logic [CNT_W-1:0] cnt;
  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] pre_mask;
  logic             at_max;

  always_comb pre_mask = PRE_W'((32'd1 << sel) - 32'd1);
  assign at_max = &cnt;

  always_ff @(posedge clk) begin
    if (clr) begin
      running <= 1'b0;
      cnt     <= '0;
      pre     <= '0;
    end else if (kick) begin
      running <= 1'b1;
      cnt     <= '0;
      pre     <= '0;
    end else if (running && tick && !at_max) begin
      if (pre == pre_mask) begin
        pre <= '0;
        cnt <= cnt + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  assign expire = running && at_max;

  // R3
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(running) |-> $past(clr));
  // R4
  kick_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (kick && !clr) |=> (cnt == '0));
  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (running && !kick && !clr && !tick) |=> $stable(cnt));
endmodule

// File: rtl/seq_wdt_pulse.sv
module seq_wdt_pulse #(
  parameter int PULSE_LEN = 96
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic expire,
  output logic pulse_o,
  output logic done
);
  localparam int LEN_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam logic [LEN_W-1:0] LAST = LEN_W'(PULSE_LEN - 1);

  logic [LEN_W-1:0] len;

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= pulse_o && (len == LAST);
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      pulse_o <= 1'b0;
      len     <= '0;
    end else if (!pulse_o) begin
      pulse_o <= expire;
      len     <= '0;
    end else if (len == LAST) begin
      pulse_o <= 1'b0;
    end else begin
      len <= len + 1'b1;
    end
  end

  // R7
  pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_o) |-> $past(expire));
  // R7
  pulse_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_o) |=> pulse_o);
endmodule

// File: rtl/seq_wdt.sv
module seq_wdt #(
  parameter int         OSC_PER_MC = 12,
  parameter int         CNT_W      = 14,
  parameter int         PSEL_W     = 3,
  parameter int         PULSE_LEN  = 96,
  parameter int         ADDR_W     = 8,
  parameter int         DATA_W     = 8,
  parameter logic [7:0] KEY_ADDR   = 8'hA6,
  parameter logic [7:0] CFG_ADDR   = 8'hA7,
  parameter logic [7:0] KEY_FIRST  = 8'h1E,
  parameter logic [7:0] KEY_SECOND = 8'hE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wdt_rst_o
);
  logic              clr;
  logic              done;
  logic              kick;
  logic              tick;
  logic              expire;
  logic [PSEL_W-1:0] sel;

  assign clr = rst | done;

  always_ff @(posedge clk) begin
    if (clr)                                         sel <= '0;
    else if (wr_en && wr_addr == ADDR_W'(CFG_ADDR))  sel <= wr_data[PSEL_W-1:0];
  end

  seq_wdt_unlock #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR),
    .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
  ) u_unlock (
    .clk(clk), .rst(rst), .clr(clr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .kick(kick)
  );

  seq_wdt_mcgen #(.OSC_PER_MC(OSC_PER_MC)) u_mcgen (
    .clk(clk), .rst(rst), .clr(clr), .restart(kick), .tick(tick)
  );

  seq_wdt_timer #(.CNT_W(CNT_W), .PSEL_W(PSEL_W)) u_timer (
    .clk(clk), .rst(rst), .clr(clr), .kick(kick), .tick(tick),
    .sel(sel), .expire(expire)
  );

  seq_wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst(rst), .clr(clr), .expire(expire),
    .pulse_o(wdt_rst_o), .done(done)
  );

  // R9
  sel_cfg_chk: assert property (@(posedge clk) disable iff (clr)
    (wr_en && wr_addr == ADDR_W'(CFG_ADDR)) |=> (sel == $past(wr_data[PSEL_W-1:0])));
  // R1
  idle_out_chk: assert property (@(posedge clk)
    $past(rst) |-> !wdt_rst_o);
endmodule

// File: tb/seq_wdt_tb.sv
module seq_wdt_tb;
  localparam int TB_CNT_W = 5;
  localparam int BASE     = 12 * ((1 << TB_CNT_W) - 1);

  // entry: {addr1, data1, addr2, data2, starts}
  localparam logic [32:0] VEC [6] = '{
    {8'hA6, 8'h1E, 8'hA6, 8'hE1, 1'b1},
    {8'hA6, 8'hE1, 8'hA6, 8'h1E, 1'b0},
    {8'hA6, 8'h1E, 8'hA6, 8'h55, 1'b0},
    {8'hA5, 8'h1E, 8'hA6, 8'hE1, 1'b0},
    {8'hA6, 8'h1E, 8'hA5, 8'hE1, 1'b0},
    {8'hA6, 8'h1E, 8'hA6, 8'h1E, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       wdt_rst_o;
  int         n_cmp = 0;
  int         n_bad = 0;

  always #5 clk = ~clk;

  seq_wdt #(.CNT_W(TB_CNT_W)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wdt_rst_o(wdt_rst_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset level", int'(wdt_rst_o), 0);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic kick();
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'hE1);
  endtask

  // entered half a clock after the completing edge
  task automatic expect_timeout(input string req, input int n);
    int w;
    repeat (n - 1) @(negedge clk);
    chk({req, " before rise"}, int'(wdt_rst_o), 0);
    @(negedge clk);
    chk({req, " at rise"}, int'(wdt_rst_o), 1);
    w = 0;
    while (wdt_rst_o && w < 1000) begin
      w++;
      @(negedge clk);
    end
    chk("R7 pulse width", w, 96);
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_quiet(input string req, input int n);
    int hi;
    hi = 0;
    repeat (n) begin
      @(negedge clk);
      if (wdt_rst_o) hi = 1;
    end
    chk(req, hi, 0);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state and idle behaviour
    do_reset();
    expect_quiet("R1 idle without key", 3 * BASE);

    // R2: two-write vectors
    for (int i = 0; i < 6; i++) begin
      do_reset();
      wr(VEC[i][32:25], VEC[i][24:17]);
      wr(VEC[i][16:9], VEC[i][8:1]);
      if (VEC[i][0]) expect_timeout("R2/R6 vector start", 2 + BASE);
      else           expect_quiet("R2 vector no start", 2 * BASE + 100);
    end

    // R2: other key value between halves clears tracker
    do_reset();
    wr(8'hA6, 8'h1E); wr(8'hA6, 8'h33); wr(8'hA6, 8'hE1);
    expect_quiet("R2 broken sequence", 2 * BASE + 100);

    // R2: write to another address between halves is ignored
    do_reset();
    wr(8'hA6, 8'h1E); wr(8'h10, 8'hE1); wr(8'hA6, 8'hE1);
    expect_timeout("R2 foreign write between", 2 + BASE);

    // R4: periodic service holds off the reset
    do_reset();
    kick();
    for (int k = 0; k < 5; k++) begin
      expect_quiet("R4 serviced no pulse", 300);
      kick();
    end
    expect_timeout("R4 timeout from last service", 2 + BASE);

    // R3: junk writes to the key register do not stop it
    do_reset();
    kick();
    repeat (100) @(negedge clk);
    wr(8'hA6, 8'h00); wr(8'hA6, 8'h1E); wr(8'hA6, 8'h77);
    expect_timeout("R3 no software stop", 2 + BASE - 106);

    // R3: external reset stops it
    do_reset();
    kick();
    repeat (200) @(negedge clk);
    do_reset();
    expect_quiet("R3 external reset stops", 2 * BASE + 100);

    // R9/R5/R6: prescale ratio 4
    do_reset();
    wr(8'hA7, 8'h02);
    kick();
    expect_timeout("R9 ratio 4", 2 + 4 * BASE);

    // R8: after the pulse it is idle and the select is back to 0
    expect_quiet("R8 idle after pulse", 2 * BASE + 100);
    kick();
    expect_timeout("R8 select cleared", 2 + BASE);

    // R9: upper data bits ignored, ratio 128
    do_reset();
    wr(8'hA7, 8'h0F);
    kick();
    expect_timeout("R9 ratio 128", 2 + 128 * BASE);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule